// File: doc/BRIEF.md
# Opcode Page Activation Stack

This block tracks which alternate opcode page the instruction decoder should use. A page-select command pushes a subpage number together with an activation length onto a small stack. The entry on top of the stack is the active page. Each retired instruction that is not itself a page command counts the top entry down. When its count runs out, the entry leaves the stack. A length of all ones marks an entry as permanent, so it never counts down. A taken branch removes every entry that is not permanent. Two further commands either clear the stack completely or remove one level.

The decoder reads `page_o`. This output carries the top entry's subpage, or the default page when the stack is empty. The entire stack state is visible as one 32-bit control-register image. Software can read this image before a call and write it back afterwards, and the write reloads the whole state in a single cycle. When several request inputs are raised in the same cycle, only the highest-priority request takes effect.

Top module: `opg_page_stack`

## Requirements
- R1: After reset the stack is empty: `active_o`=0, `page_o`=DEFAULT_PAGE (0), and `csr_rdata_o`=0.
- R2: A push stores {page, length} as a new top entry, and the depth grows by one. The register image holds entry k with its length in bits [7k+3:7k] and its page in bits [7k+6:7k+4]. Entry 0 is the bottom of the stack. The depth sits in bits [30:28], and bit 31 reads 0.
- R3: A retire on a top entry whose length is not 15 reduces that length by one. If the length was 1 or 0, the retire removes the entry instead.
- R4: A retire leaves a top entry of length 15 (permanent) unchanged.
- R5: A push onto a full stack (depth 4) overwrites the top entry and keeps the depth at 4.
- R6: A pop removes the top entry. A pop on an empty stack changes nothing.
- R7: A clear command empties the stack in one cycle.
- R8: A taken branch removes every non-permanent entry. The permanent entries keep their relative order and are compacted down to the bottom of the stack.
- R9: A register write loads all entries and the depth in one cycle. A depth field above 4 loads as 4.
- R10: Priority, highest first: register write, clear, branch, push, pop, retire. Only one of them acts in any cycle.
- R11: `page_o` shows the page of the top entry, or DEFAULT_PAGE when the stack is empty. The register image reads entries at or above the depth as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | A non-page instruction retired |
| push_i | input | 1 | Page-select command |
| push_page_i | input | 3 | Subpage to push |
| push_len_i | input | 4 | Activation length (15 = permanent) |
| pop_i | input | 1 | Remove one level |
| clear_i | input | 1 | Return to the default page |
| branch_i | input | 1 | Taken branch |
| csr_we_i | input | 1 | Load the whole state from csr_wdata_i |
| csr_wdata_i | input | 32 | State image to load |
| page_o | output | 3 | Page in use by the decoder |
| active_o | output | 1 | Stack is not empty |
| csr_rdata_o | output | 32 | Current state image |

## Verification
All state is held in registers, and both `page_o` and the register image are combinational views of that state. A wrong depth or a wrong entry therefore shows up one cycle after the command that caused it. A bad depth appears in bits [30:28], and a bad top entry appears on `page_o`. An error in the length countdown is only latent until the retire that should end an entry's activation. For that reason the bench walks lengths of 0, 1, 2 and 15 through the retire path and compares the image after every step. Branch compaction is checked with permanent and temporary entries interleaved, which would expose a wrong kept order in the low entry fields.

// File: rtl/opg_pkg.sv
package opg_pkg;
  localparam int unsigned PAGE_W_DEF = 3;
  localparam int unsigned LEN_W_DEF  = 4;
  localparam int unsigned DEPTH_DEF  = 4;
  localparam int unsigned REG_W_DEF  = 32;

  // one action per cycle, chosen by priority
  typedef enum logic [2:0] {
    OP_IDLE, OP_LOAD, OP_CLEAR, OP_FLUSH, OP_PUSH, OP_POP, OP_RETIRE
  } op_e;
endpackage

// File: rtl/opg_cmd_arb.sv
module opg_cmd_arb
  import opg_pkg::*;
(
  input  logic csr_we_i,
  input  logic clear_i,
  input  logic branch_i,
  input  logic push_i,
  input  logic pop_i,
  input  logic retire_i,
  output op_e  op_o
);
  always_comb begin
    if (csr_we_i)      op_o = OP_LOAD;
    else if (clear_i)  op_o = OP_CLEAR;
    else if (branch_i) op_o = OP_FLUSH;
    else if (push_i)   op_o = OP_PUSH;
    else if (pop_i)    op_o = OP_POP;
    else if (retire_i) op_o = OP_RETIRE;
    else               op_o = OP_IDLE;
  end
endmodule

// File: rtl/opg_next_state.sv
module opg_next_state
  import opg_pkg::*;
#(
  parameter int unsigned PAGE_W = PAGE_W_DEF,
  parameter int unsigned LEN_W  = LEN_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF,
  parameter int unsigned REG_W  = REG_W_DEF,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  op_e                          op_i,
  input  logic [DEPTH-1:0][PAGE_W-1:0] pg_q,
  input  logic [DEPTH-1:0][LEN_W-1:0]  ln_q,
  input  logic [CNT_W-1:0]             dep_q,
  input  logic [PAGE_W-1:0]            push_page_i,
  input  logic [LEN_W-1:0]             push_len_i,
  input  logic [REG_W-1:0]             wdata_i,
  output logic [DEPTH-1:0][PAGE_W-1:0] pg_d,
  output logic [DEPTH-1:0][LEN_W-1:0]  ln_d,
  output logic [CNT_W-1:0]             dep_d,
  output logic                         expire_o
);
  localparam int unsigned ENT_W   = PAGE_W + LEN_W;
  localparam int unsigned DEP_LSB = DEPTH * ENT_W;
  localparam logic [LEN_W-1:0] LEN_PERM = '1;

  function automatic logic [CNT_W-1:0] clamp_depth(input logic [CNT_W-1:0] d);
    return (d > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : d;
  endfunction

  function automatic logic runs_out(input logic [LEN_W-1:0] l);
    return l <= LEN_W'(1);
  endfunction

  logic [IDX_W-1:0] top_idx;
  logic [CNT_W-1:0] kept;
  assign top_idx = IDX_W'(dep_q - 1'b1);

  if (REG_W > DEP_LSB + CNT_W) begin : g_spare
    logic unused_hi;
    assign unused_hi = ^wdata_i[REG_W-1:DEP_LSB+CNT_W];
  end

  always_comb begin
    pg_d     = pg_q;
    ln_d     = ln_q;
    dep_d    = dep_q;
    expire_o = 1'b0;
    kept     = '0;
    case (op_i)
      OP_LOAD: begin
        for (int k = 0; k < DEPTH; k++) begin
          ln_d[k] = wdata_i[k*ENT_W +: LEN_W];
          pg_d[k] = wdata_i[k*ENT_W+LEN_W +: PAGE_W];
        end
        dep_d = clamp_depth(wdata_i[DEP_LSB +: CNT_W]);
      end
      OP_CLEAR: dep_d = '0;
      OP_FLUSH: begin
        for (int k = 0; k < DEPTH; k++) begin
          if (CNT_W'(k) < dep_q && ln_q[k] == LEN_PERM) begin
            pg_d[kept[IDX_W-1:0]] = pg_q[k];
            ln_d[kept[IDX_W-1:0]] = ln_q[k];
            kept = kept + 1'b1;
          end
        end
        dep_d = kept;
      end
      OP_PUSH: begin
        if (dep_q == CNT_W'(DEPTH)) begin
          pg_d[top_idx] = push_page_i;
          ln_d[top_idx] = push_len_i;
        end else begin
          pg_d[dep_q[IDX_W-1:0]] = push_page_i;
          ln_d[dep_q[IDX_W-1:0]] = push_len_i;
          dep_d = dep_q + 1'b1;
        end
      end
      OP_POP: if (dep_q != '0) dep_d = dep_q - 1'b1;
      OP_RETIRE: begin
        if (dep_q != '0 && ln_q[top_idx] != LEN_PERM) begin
          if (runs_out(ln_q[top_idx])) begin
            dep_d    = dep_q - 1'b1;
            expire_o = 1'b1;
          end else begin
            ln_d[top_idx] = ln_q[top_idx] - 1'b1;
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opg_view.sv
module opg_view
  import opg_pkg::*;
#(
  parameter int unsigned PAGE_W = PAGE_W_DEF,
  parameter int unsigned LEN_W  = LEN_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF,
  parameter int unsigned REG_W  = REG_W_DEF,
  parameter logic [PAGE_W-1:0] DEFAULT_PAGE = '0,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][PAGE_W-1:0] pg_q,
  input  logic [DEPTH-1:0][LEN_W-1:0]  ln_q,
  input  logic [CNT_W-1:0]             dep_q,
  output logic [PAGE_W-1:0]            page_o,
  output logic                         active_o,
  output logic [REG_W-1:0]             rdata_o
);
  localparam int unsigned ENT_W   = PAGE_W + LEN_W;
  localparam int unsigned DEP_LSB = DEPTH * ENT_W;

  logic [IDX_W-1:0] top_idx;
  assign top_idx  = IDX_W'(dep_q - 1'b1);
  assign active_o = (dep_q != '0);
  assign page_o   = active_o ? pg_q[top_idx] : DEFAULT_PAGE;

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    assign rdata_o[k*ENT_W +: ENT_W] =
      (CNT_W'(k) < dep_q) ? {pg_q[k], ln_q[k]} : '0;
  end
  assign rdata_o[DEP_LSB +: CNT_W] = dep_q;
  if (REG_W > DEP_LSB + CNT_W) begin : g_pad
    assign rdata_o[REG_W-1:DEP_LSB+CNT_W] = '0;
  end
endmodule

// File: rtl/opg_page_stack.sv
module opg_page_stack
  import opg_pkg::*;
#(
  parameter int unsigned PAGE_W = PAGE_W_DEF,
  parameter int unsigned LEN_W  = LEN_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF,
  parameter int unsigned REG_W  = REG_W_DEF,
  parameter logic [PAGE_W-1:0] DEFAULT_PAGE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  input  logic              push_i,
  input  logic [PAGE_W-1:0] push_page_i,
  input  logic [LEN_W-1:0]  push_len_i,
  input  logic              pop_i,
  input  logic              clear_i,
  input  logic              branch_i,
  input  logic              csr_we_i,
  input  logic [REG_W-1:0]  csr_wdata_i,
  output logic [PAGE_W-1:0] page_o,
  output logic              active_o,
  output logic [REG_W-1:0]  csr_rdata_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  op_e                          op;
  logic [DEPTH-1:0][PAGE_W-1:0] pg_q, pg_d;
  logic [DEPTH-1:0][LEN_W-1:0]  ln_q, ln_d;
  logic [CNT_W-1:0]             dep_q, dep_d;
  logic                         ev_expire;

  opg_cmd_arb i_arb (
    .csr_we_i (csr_we_i),
    .clear_i  (clear_i),
    .branch_i (branch_i),
    .push_i   (push_i),
    .pop_i    (pop_i),
    .retire_i (retire_i),
    .op_o     (op)
  );

  opg_next_state #(
    .PAGE_W(PAGE_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .REG_W(REG_W)
  ) i_next (
    .op_i        (op),
    .pg_q        (pg_q),
    .ln_q        (ln_q),
    .dep_q       (dep_q),
    .push_page_i (push_page_i),
    .push_len_i  (push_len_i),
    .wdata_i     (csr_wdata_i),
    .pg_d        (pg_d),
    .ln_d        (ln_d),
    .dep_d       (dep_d),
    .expire_o    (ev_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_q  <= '0;
      ln_q  <= '0;
      dep_q <= '0;
    end else begin
      pg_q  <= pg_d;
      ln_q  <= ln_d;
      dep_q <= dep_d;
    end
  end

  opg_view #(
    .PAGE_W(PAGE_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .REG_W(REG_W),
    .DEFAULT_PAGE(DEFAULT_PAGE)
  ) i_view (
    .pg_q     (pg_q),
    .ln_q     (ln_q),
    .dep_q    (dep_q),
    .page_o   (page_o),
    .active_o (active_o),
    .rdata_o  (csr_rdata_o)
  );
endmodule

// File: rtl/opg_page_stack_chk.sv
module opg_page_stack_chk #(
  parameter int unsigned PAGE_W = 3,
  parameter int unsigned LEN_W  = 4,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned REG_W  = 32,
  parameter logic [PAGE_W-1:0] DEFAULT_PAGE = '0,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              retire_i,
  input logic              push_i,
  input logic [PAGE_W-1:0] push_page_i,
  input logic              pop_i,
  input logic              clear_i,
  input logic              branch_i,
  input logic              csr_we_i,
  input logic [REG_W-1:0]  csr_wdata_i,
  input logic [PAGE_W-1:0] page_o,
  input logic              active_o,
  input logic [REG_W-1:0]  csr_rdata_o,
  input logic              ev_expire
);
  localparam int unsigned DEP_LSB = DEPTH * (PAGE_W + LEN_W);

  logic [CNT_W-1:0] depth, wdepth;
  logic             unused_w;
  assign depth    = csr_rdata_o[DEP_LSB +: CNT_W];
  assign wdepth   = csr_wdata_i[DEP_LSB +: CNT_W];
  assign unused_w = ^csr_wdata_i ^ retire_i;

  // R11
  default_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> page_o == DEFAULT_PAGE);

  // R5
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(DEPTH));

  // R7
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !csr_we_i) |=> !active_o);

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && pop_i && !csr_we_i && !clear_i && !branch_i && !push_i)
    |=> $stable(csr_rdata_o));

  // R2
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !csr_we_i && !clear_i && !branch_i && depth < CNT_W'(DEPTH))
    |=> (page_o == $past(push_page_i) && depth == $past(depth) + 1'b1));

  // R3
  expire_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_expire |=> depth == $past(depth) - 1'b1);

  // R9
  load_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we_i && wdepth <= CNT_W'(DEPTH)) |=> depth == $past(wdepth));
endmodule

bind opg_page_stack opg_page_stack_chk #(
  .PAGE_W(PAGE_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .REG_W(REG_W),
  .DEFAULT_PAGE(DEFAULT_PAGE)
) i_chk (
  .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .push_i(push_i),
  .push_page_i(push_page_i), .pop_i(pop_i), .clear_i(clear_i),
  .branch_i(branch_i), .csr_we_i(csr_we_i), .csr_wdata_i(csr_wdata_i),
  .page_o(page_o), .active_o(active_o), .csr_rdata_o(csr_rdata_o),
  .ev_expire(ev_expire)
);

// File: tb/test_opg_page_stack.sv
module test_opg_page_stack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire_i = 0, push_i = 0, pop_i = 0, clear_i = 0, branch_i = 0, csr_we_i = 0;
  logic [2:0]  push_page_i = '0;
  logic [3:0]  push_len_i = '0;
  logic [31:0] csr_wdata_i = '0;
  logic [2:0]  page_o;
  logic        active_o;
  logic [31:0] csr_rdata_o;

  int checks = 0;
  int errors = 0;
  int mp[4];
  int ml[4];
  int md = 0;

  always #10 clk = ~clk;

  opg_page_stack i_opg_page_stack (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .push_i(push_i),
    .push_page_i(push_page_i), .push_len_i(push_len_i), .pop_i(pop_i),
    .clear_i(clear_i), .branch_i(branch_i), .csr_we_i(csr_we_i),
    .csr_wdata_i(csr_wdata_i), .page_o(page_o), .active_o(active_o),
    .csr_rdata_o(csr_rdata_o)
  );

  // expected image: entry k = {page,len} at 7k, depth at 28, only below depth
  function automatic logic [31:0] exp_image();
    logic [31:0] r = '0;
    for (int k = 0; k < md; k++)
      r |= 32'((mp[k] << 4) | ml[k]) << (7 * k);
    r |= 32'(md) << 28;
    return r;
  endfunction

  function automatic logic [3:0] exp_page();
    return (md > 0) ? {1'b1, 3'(mp[md-1])} : 4'b0000;
  endfunction

  task automatic model_apply();
    if (csr_we_i) begin
      for (int k = 0; k < 4; k++) begin
        ml[k] = int'(csr_wdata_i[7*k +: 4]);
        mp[k] = int'(csr_wdata_i[7*k+4 +: 3]);
      end
      md = (csr_wdata_i[30:28] > 3'd4) ? 4 : int'(csr_wdata_i[30:28]);
    end else if (clear_i) begin
      md = 0;
    end else if (branch_i) begin
      int n = 0;
      for (int k = 0; k < md; k++)
        if (ml[k] == 15) begin mp[n] = mp[k]; ml[n] = ml[k]; n++; end
      md = n;
    end else if (push_i) begin
      if (md == 4) begin mp[3] = int'(push_page_i); ml[3] = int'(push_len_i); end
      else begin mp[md] = int'(push_page_i); ml[md] = int'(push_len_i); md++; end
    end else if (pop_i) begin
      if (md > 0) md--;
    end else if (retire_i) begin
      if (md > 0 && ml[md-1] != 15) begin
        if (ml[md-1] <= 1) md--;
        else ml[md-1] = ml[md-1] - 1;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    model_apply();
    {retire_i, push_i, pop_i, clear_i, branch_i, csr_we_i} = '0;
  endtask

  task automatic check(input string req);
    checks++;
    if (csr_rdata_o !== exp_image()) begin
      errors++;
      $display("FAIL %s image actual=%h expected=%h", req, csr_rdata_o, exp_image());
    end
    checks++;
    if ({active_o, page_o} !== exp_page()) begin
      errors++;
      $display("FAIL %s active/page actual=%b expected=%b", req, {active_o, page_o}, exp_page());
    end
  endtask

  task automatic do_push(input int pg, input int ln);
    push_i = 1; push_page_i = 3'(pg); push_len_i = 4'(ln); tick();
  endtask
  task automatic do_retire(); retire_i = 1; tick(); endtask
  task automatic do_pop();    pop_i = 1;    tick(); endtask
  task automatic do_clear();  clear_i = 1;  tick(); endtask

  task automatic t_reset();
    check("R1");
    check("R11");
  endtask

  task automatic t_push();
    do_push(5, 3); check("R2");
    do_push(2, 15); check("R2");
  endtask

  task automatic t_retire();
    do_clear();
    do_push(6, 2);
    do_retire(); check("R3");
    do_retire(); check("R3");
    do_push(1, 0);
    do_retire(); check("R3");
  endtask

  task automatic t_perm();
    do_clear();
    do_push(3, 15);
    for (int i = 0; i < 3; i++) begin do_retire(); check("R4"); end
  endtask

  task automatic t_full();
    do_clear();
    do_push(1, 5); do_push(2, 6); do_push(3, 7); do_push(4, 8);
    check("R5");
    do_push(7, 9); check("R5");
  endtask

  task automatic t_pop();
    do_pop(); check("R6");
    do_clear();
    do_pop(); check("R6");
  endtask

  task automatic t_clear();
    do_push(2, 15); do_push(4, 4);
    do_clear(); check("R7");
  endtask

  task automatic t_branch();
    do_clear();
    do_push(1, 15); do_push(2, 5); do_push(4, 15); do_push(6, 3);
    branch_i = 1; tick(); check("R8");
    branch_i = 1; tick(); check("R8");
    do_push(5, 2);
    branch_i = 1; tick(); check("R8");
  endtask

  task automatic t_csr();
    csr_we_i = 1; csr_wdata_i = {1'b0, 3'd2, 7'h7f, 7'h55, 7'h3a, 7'h2c}; tick();
    check("R9"); check("R11");
    csr_we_i = 1; csr_wdata_i = {1'b1, 3'd7, 7'h11, 7'h22, 7'h33, 7'h44}; tick();
    check("R9");
    do_pop(); check("R11");
  endtask

  task automatic t_prio();
    do_clear();
    push_i = 1; pop_i = 1; push_page_i = 3'd3; push_len_i = 4'd2; tick(); check("R10");
    pop_i = 1; retire_i = 1; tick(); check("R10");
    do_push(6, 15); do_push(2, 3);
    branch_i = 1; push_i = 1; push_page_i = 3'd1; push_len_i = 4'd1; tick(); check("R10");
    clear_i = 1; push_i = 1; tick(); check("R10");
    csr_we_i = 1; clear_i = 1; csr_wdata_i = {4'b0001, 21'd0, 7'h5e}; tick(); check("R10");
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_push();
    t_retire();
    t_perm();
    t_full();
    t_pop();
    t_clear();
    t_branch();
    t_csr();
    t_prio();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule